// File: doc/BRIEF.md
# DMA Shared Control and Interrupt Hub

This block is the common register file that sits beside the channel engines of a multi-channel DMA controller. Software reaches it through a single-cycle 32-bit register port. Through that port it sets the global enable and mode bits. It also reads and acknowledges per-channel interrupt causes, turns channel clocks on and off, and rings a doorbell that makes a channel fetch its first descriptor.

Each channel reports three kinds of event: normal termination, halt and address error. Any of them marks the channel as pending. A halt or an address error on any channel also raises a sticky global flag in the control register. The pending vector is OR-reduced into one interrupt line, and that line is gated by the master enable. The channel count is a parameter, from 6 channels in small builds up to 32.

Top module: `dma_hub_ctrl`

## Requirements
- R1: After reset every register reads zero, and `ch_kick`, `ch_clk_en` and `irq` are all low.
- R2: The control register at offset 0x00 stores bit 0 (master enable), bit 27 and bit 31 from a write and returns them on a read. Its other bits read zero, except the flags of R3.
- R3: Control bit 3 (halt flag) is set in the same cycle by a halt event on any channel. Control bit 2 (address-error flag) is set in the same cycle by an address-error event on any channel. Writing a one to either flag does not set it. Writing a zero clears it, and the other control bits take the written value. An event in the same cycle as a clearing write leaves the flag set.
- R4: Bit n of the pending register at 0x04 is set by a termination, halt or address-error event on channel n. A write clears exactly the bits written as zero, and writing a one never sets a bit. An event in the same cycle as a clearing write leaves its bit set.
- R5: `irq` is high exactly when the master enable is set and at least one pending bit is set.
- R6: Writing 0x0C raises `ch_kick[n]` for exactly one cycle, the cycle after the write, for each bit n written as one. The same write sets bit n of the doorbell status at 0x08. Zero bits have no effect.
- R7: The doorbell status at 0x08 can also be written directly, and it reads back the written value.
- R8: The clock-enable register at 0x10 drives `ch_clk_en`. A write to 0x10 replaces it. A write to 0x14 sets the bits written as one, and a write to 0x18 clears the bits written as one. Zero bits in those two aliases leave their bits unchanged.
- R9: The channel-select register at 0x1C stores one bit per channel and reads it back.
- R10: Reads of 0x0C, 0x14, 0x18 and of any unmapped offset return zero, and bits above the channel count always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_term | input | NCH | Per-channel termination event |
| ev_halt | input | NCH | Per-channel halt event |
| ev_aerr | input | NCH | Per-channel address-error event |
| ch_kick | output | NCH | One-cycle descriptor-fetch pulse per channel |
| ch_clk_en | output | NCH | Per-channel clock enable |
| irq | output | 1 | Combined interrupt to the CPU |

## Verification
Pending bits are raised one at a time, each by a different event kind. This shows that all three event inputs reach the pending vector, and that only halt and address error reach the global flags. Clearing writes use mixed masks, so a clear that hits only the bits written as zero can be told apart from a write that replaces the whole register. Writes that collide with events in the same cycle separate "event wins" from "write wins". Writes to the set and clear aliases of the clock enable, with several bits at once, separate alias behaviour from a direct overwrite.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PEND    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_BELL    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_BELLSET = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CKEN    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CKSET   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CKCLR   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CHSEL   = 8'h1C;

  localparam int CB_ENABLE    = 0;
  localparam int CB_ADDR_FLAG = 2;
  localparam int CB_HALT_FLAG = 3;
  localparam int CB_MODE_A    = 27;
  localparam int CB_MODE_B    = 31;

  typedef struct packed {
    logic ctrl;
    logic pend;
    logic bell;
    logic bellset;
    logic cken;
    logic ckset;
    logic ckclr;
    logic chsel;
  } wr_strobe_t;
endpackage

// File: rtl/dhc_ctrl_reg.sv
module dhc_ctrl_reg
  import dhc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              any_halt,
  input  logic              any_aerr,
  output logic              master_en,
  output logic [DATA_W-1:0] ctrl_rd
);
  logic en_q, en_n;
  logic mode_a_q, mode_a_n;
  logic mode_b_q, mode_b_n;
  logic halt_q, halt_n;
  logic aerr_q, aerr_n;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[30:28], wdata[26:4], wdata[1]};

  always_comb begin
    en_n     = en_q;
    mode_a_n = mode_a_q;
    mode_b_n = mode_b_q;
    halt_n   = halt_q;
    aerr_n   = aerr_q;
    if (wr) begin
      en_n     = wdata[CB_ENABLE];
      mode_a_n = wdata[CB_MODE_A];
      mode_b_n = wdata[CB_MODE_B];
      halt_n   = halt_q & wdata[CB_HALT_FLAG];
      aerr_n   = aerr_q & wdata[CB_ADDR_FLAG];
    end
    halt_n = halt_n | any_halt;
    aerr_n = aerr_n | any_aerr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      mode_a_q <= 1'b0;
      mode_b_q <= 1'b0;
      halt_q   <= 1'b0;
      aerr_q   <= 1'b0;
    end else begin
      en_q     <= en_n;
      mode_a_q <= mode_a_n;
      mode_b_q <= mode_b_n;
      halt_q   <= halt_n;
      aerr_q   <= aerr_n;
    end
  end

  always_comb begin
    ctrl_rd               = '0;
    ctrl_rd[CB_ENABLE]    = en_q;
    ctrl_rd[CB_ADDR_FLAG] = aerr_q;
    ctrl_rd[CB_HALT_FLAG] = halt_q;
    ctrl_rd[CB_MODE_A]    = mode_a_q;
    ctrl_rd[CB_MODE_B]    = mode_b_q;
  end

  assign master_en = en_q;

  p_halt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_halt |=> halt_q);
  p_aerr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_aerr |=> aerr_q);
  p_halt_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr) |=> halt_q);
endmodule

// File: rtl/dhc_pend_vec.sv
module dhc_pend_vec #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] ev_term,
  input  logic [NCH-1:0] ev_halt,
  input  logic [NCH-1:0] ev_aerr,
  output logic [NCH-1:0] pend_q
);
  logic [NCH-1:0] ev_any;
  logic [NCH-1:0] pend_n;

  assign ev_any = ev_term | ev_halt | ev_aerr;

  always_comb begin
    pend_n = pend_q;
    if (wr) pend_n = pend_q & wdata;
    pend_n = pend_n | ev_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_any) |=> ((pend_q & $past(ev_any)) == $past(ev_any)));
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ev_any) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/dhc_bit_bank.sv
module dhc_bit_bank #(
  parameter int W       = 6,
  parameter bit HAS_SET = 1'b1,
  parameter bit HAS_CLR = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_direct,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;
  logic [W-1:0] q_n;

  generate
    if (HAS_SET) begin : g_set
      assign set_mask = wr_set ? wdata : '0;
    end else begin : g_noset
      logic unused_set;
      assign unused_set = wr_set;
      assign set_mask   = '0;
    end
    if (HAS_CLR) begin : g_clr
      assign clr_mask = wr_clr ? wdata : '0;
    end else begin : g_noclr
      logic unused_clr;
      assign unused_clr = wr_clr;
      assign clr_mask   = '0;
    end
  endgenerate

  always_comb begin
    q_n = q;
    if (wr_direct) q_n = wdata;
    q_n = (q_n | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  generate
    if (HAS_SET) begin : g_set_chk
      // R6 and R8: a set alias only raises bits
      p_set_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_direct && !wr_clr) |=>
          ((q & $past(wdata)) == $past(wdata)) && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
    end
    if (HAS_CLR) begin : g_clr_chk
      p_clr_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_set) |=> ((q & $past(wdata)) == '0));
    end
  endgenerate
endmodule

// File: rtl/dhc_kick_gen.sv
module dhc_kick_gen #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_set,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] kick_q
);
  logic [NCH-1:0] kick_n;

  always_comb begin
    kick_n = '0;
    if (wr_set) kick_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kick_q <= '0;
    else        kick_q <= kick_n;
  end

  p_kick_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|kick_q) |-> $past(wr_set));
  p_kick_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_set |=> (kick_q == '0));
endmodule

// File: rtl/dma_hub_ctrl.sv
module dma_hub_ctrl
  import dhc_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    ev_term,
  input  logic [NCH-1:0]    ev_halt,
  input  logic [NCH-1:0]    ev_aerr,
  output logic [NCH-1:0]    ch_kick,
  output logic [NCH-1:0]    ch_clk_en,
  output logic              irq
);
  wr_strobe_t     ws;
  logic [NCH-1:0] wd_ch;
  logic [DATA_W-1:0] ctrl_rd;
  logic           master_en;
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] bell_q;
  logic [NCH-1:0] chsel_q;
  logic           unused_wdata;

  assign wd_ch        = reg_wdata[NCH-1:0];
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    ws = '0;
    if (reg_wen) begin
      unique case (reg_addr)
        OFS_CTRL:    ws.ctrl    = 1'b1;
        OFS_PEND:    ws.pend    = 1'b1;
        OFS_BELL:    ws.bell    = 1'b1;
        OFS_BELLSET: ws.bellset = 1'b1;
        OFS_CKEN:    ws.cken    = 1'b1;
        OFS_CKSET:   ws.ckset   = 1'b1;
        OFS_CKCLR:   ws.ckclr   = 1'b1;
        OFS_CHSEL:   ws.chsel   = 1'b1;
        default:     ws = '0;
      endcase
    end
  end

  dhc_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (ws.ctrl),
    .wdata     (reg_wdata),
    .any_halt  (|ev_halt),
    .any_aerr  (|ev_aerr),
    .master_en (master_en),
    .ctrl_rd   (ctrl_rd)
  );

  dhc_pend_vec #(.NCH(NCH)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ws.pend),
    .wdata   (wd_ch),
    .ev_term (ev_term),
    .ev_halt (ev_halt),
    .ev_aerr (ev_aerr),
    .pend_q  (pend_q)
  );

  dhc_bit_bank #(.W(NCH), .HAS_SET(1'b1), .HAS_CLR(1'b0)) u_bell (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_direct (ws.bell),
    .wr_set    (ws.bellset),
    .wr_clr    (1'b0),
    .wdata     (wd_ch),
    .q         (bell_q)
  );

  dhc_kick_gen #(.NCH(NCH)) u_kick (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_set (ws.bellset),
    .wdata  (wd_ch),
    .kick_q (ch_kick)
  );

  dhc_bit_bank #(.W(NCH), .HAS_SET(1'b1), .HAS_CLR(1'b1)) u_cken (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_direct (ws.cken),
    .wr_set    (ws.ckset),
    .wr_clr    (ws.ckclr),
    .wdata     (wd_ch),
    .q         (ch_clk_en)
  );

  dhc_bit_bank #(.W(NCH), .HAS_SET(1'b0), .HAS_CLR(1'b0)) u_chsel (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_direct (ws.chsel),
    .wr_set    (1'b0),
    .wr_clr    (1'b0),
    .wdata     (wd_ch),
    .q         (chsel_q)
  );

  assign irq = master_en & (|pend_q);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL:  reg_rdata = ctrl_rd;
      OFS_PEND:  reg_rdata[NCH-1:0] = pend_q;
      OFS_BELL:  reg_rdata[NCH-1:0] = bell_q;
      OFS_CKEN:  reg_rdata[NCH-1:0] = ch_clk_en;
      OFS_CHSEL: reg_rdata[NCH-1:0] = chsel_q;
      default:   reg_rdata = '0;
    endcase
  end

  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ws.ctrl) && !$past(reg_wdata[CB_ENABLE])) |-> !irq);
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ws));
endmodule

// File: tb/sim_dma_hub_ctrl.sv
`timescale 1ns/1ps
module sim_dma_hub_ctrl;
  localparam int NCH = 6;

  logic clk;
  logic rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wen;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] ev_term, ev_halt, ev_aerr;
  logic [NCH-1:0] ch_kick, ch_clk_en;
  logic irq;

  int checks;
  int failures;
  bit done;

  typedef struct {
    int          kind;
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb[$];

  dma_hub_ctrl #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_term(ev_term),
    .ev_halt(ev_halt), .ev_aerr(ev_aerr), .ch_kick(ch_kick),
    .ch_clk_en(ch_clk_en), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: pops expected items and compares with the observed signal
  initial begin
    forever begin
      sb_item_t it;
      logic [31:0] act;
      wait (sb.size() != 0);
      #1;
      it = sb.pop_front();
      case (it.kind)
        0:       act = reg_rdata;
        1:       act = {26'd0, ch_kick};
        2:       act = {26'd0, ch_clk_en};
        default: act = {31'd0, irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s: kind=%0d addr=%h actual=%h expected=%h",
                 it.tag, it.kind, it.addr, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wen   = 1'b1;
    tick();
    reg_wen   = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    if (kind == 0) reg_addr = a;
    it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    #2;
  endtask

  task automatic pulse_ev(input logic [NCH-1:0] t, input logic [NCH-1:0] h, input logic [NCH-1:0] a);
    ev_term = t; ev_halt = h; ev_aerr = a;
    tick();
    ev_term = '0; ev_halt = '0; ev_aerr = '0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; reg_addr = '0; reg_wen = 1'b0; reg_wdata = '0;
    ev_term = '0; ev_halt = '0; ev_aerr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk(0, 8'h00, 32'h0, "R1 ctrl");
    chk(0, 8'h04, 32'h0, "R1 pend");
    chk(1, 8'h00, 32'h0, "R1 kick");
    chk(3, 8'h00, 32'h0, "R1 irq");
    tick();
    chk(0, 8'h10, 32'h0, "R1 cken");
    chk(2, 8'h00, 32'h0, "R1 clk_en");

    // R2 stored bits, R3 flags not set by writing one
    wr(8'h00, 32'hFFFF_FFFF);
    chk(0, 8'h00, 32'h8800_0001, "R2 R3 ctrl readback");
    wr(8'h00, 32'h0000_0001);
    chk(0, 8'h00, 32'h0000_0001, "R2 ctrl enable only");

    // R8 clock enable aliases
    wr(8'h10, 32'h05);
    chk(2, 8'h00, 32'h05, "R8 direct");
    wr(8'h14, 32'h22);
    chk(2, 8'h00, 32'h27, "R8 set alias");
    wr(8'h18, 32'h03);
    chk(2, 8'h00, 32'h24, "R8 clear alias");
    chk(0, 8'h10, 32'h24, "R8 readback");
    chk(0, 8'h14, 32'h0, "R10 set alias reads zero");
    tick();
    chk(0, 8'h18, 32'h0, "R10 clear alias reads zero");

    // R6 doorbell pulses, R7 status
    wr(8'h0C, 32'h12);
    chk(1, 8'h00, 32'h12, "R6 kick pulse");
    tick();
    chk(1, 8'h00, 32'h00, "R6 kick ends");
    chk(0, 8'h08, 32'h12, "R6 status set");
    wr(8'h0C, 32'h01);
    chk(0, 8'h08, 32'h13, "R6 zero bits keep");
    chk(0, 8'h0C, 32'h0, "R10 doorbell-set reads zero");
    tick();
    chk(1, 8'h00, 32'h00, "R6 single cycle");
    wr(8'h08, 32'h00);
    chk(0, 8'h08, 32'h0, "R7 direct write");

    // R4 R5 pending and interrupt
    pulse_ev(6'h04, 6'h00, 6'h00);
    chk(0, 8'h04, 32'h04, "R4 term sets pend");
    chk(3, 8'h00, 32'h1, "R5 irq on");
    chk(0, 8'h00, 32'h1, "R3 term no flag");
    pulse_ev(6'h00, 6'h10, 6'h00);
    chk(0, 8'h04, 32'h14, "R4 halt sets pend");
    chk(0, 8'h00, 32'h9, "R3 halt flag");
    pulse_ev(6'h00, 6'h00, 6'h01);
    chk(0, 8'h04, 32'h15, "R4 aerr sets pend");
    chk(0, 8'h00, 32'hD, "R3 aerr flag");
    wr(8'h04, 32'h3B);
    chk(0, 8'h04, 32'h11, "R4 clear by zero bit");
    wr(8'h00, 32'h1);
    chk(0, 8'h00, 32'h1, "R3 flags cleared");
    chk(3, 8'h00, 32'h1, "R5 irq still on");
    wr(8'h00, 32'h0);
    chk(3, 8'h00, 32'h0, "R5 irq gated off");
    chk(0, 8'h04, 32'h11, "R5 pend kept");
    wr(8'h00, 32'h1);
    chk(3, 8'h00, 32'h1, "R5 irq back");

    // R4 event beats clearing write
    reg_addr = 8'h04; reg_wdata = 32'h0; reg_wen = 1'b1; ev_term = 6'h01;
    tick();
    reg_wen = 1'b0; ev_term = '0;
    chk(0, 8'h04, 32'h01, "R4 event wins");
    // R3 event beats flag clear
    reg_addr = 8'h00; reg_wdata = 32'h1; reg_wen = 1'b1; ev_halt = 6'h02;
    tick();
    reg_wen = 1'b0; ev_halt = '0;
    chk(0, 8'h00, 32'h9, "R3 event wins");
    chk(0, 8'h04, 32'h03, "R4 halt pend");
    wr(8'h04, 32'h0);
    chk(0, 8'h04, 32'h0, "R4 all cleared");
    chk(3, 8'h00, 32'h0, "R5 irq off no pend");

    // R9 select, R10 unmapped and upper bits
    wr(8'h1C, 32'hFFFF_FFFF);
    chk(0, 8'h1C, 32'h3F, "R9 R10 select");
    chk(0, 8'h20, 32'h0, "R10 unmapped 0x20");
    chk(0, 8'hFC, 32'h0, "R10 unmapped 0xFC");
    wr(8'h10, 32'hFFFF_FFFF);
    chk(0, 8'h10, 32'h3F, "R10 cken upper bits");

    wait (sb.size() == 0);
    #5;
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule